// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block stores the alarm time of a real-time clock as three separate fields (second, minute, hour). It compares them with the running time-of-day values that a separate timekeeping block supplies. Each field has its own compare-enable input. A field with its enable low is treated as always matching. When every enabled field equals its live counterpart and at least one field is enabled, a sticky alarm flag is set. The flag stays high until a clear strobe is applied.

Software reaches the three alarm fields through a small byte-wide register bus. Writes are clocked and reads are combinational. Bit positions above each field's width read as zero. The live hour input carries day-of-week information in its top three bits, and the hour comparison ignores those bits.

There are two resets. The ordinary reset clears only the alarm flag. The backup-power-loss reset also loads the alarm fields with a fixed pattern, which stands in for their undefined contents.

Top module: `rtc_alarm_match`

## Requirements
- R1: While `por_n` is low at a clock edge, the alarm fields load 2Ah (second, address F3h), 15h (minute, address F4h) and 13h (hour, address F5h), and the flag clears. These values can be read back once `por_n` is high.
- R2: A clock edge with `rst_n` low clears `alarm_flag` and leaves all three alarm fields unchanged.
- R3: A write to F3h or F4h stores `bus_wdata[5:0]`, and a write to F5h stores `bus_wdata[4:0]`. Reads return zero above bit 5 (second, minute) and above bit 4 (hour). Any other address reads 00h, and a write to it changes no field.
- R4: `alarm_flag` rises on the first clock edge at which every enabled field equals its live value and at least one enable is high. It is visible after that edge.
- R5: A field whose enable is low does not take part in the match, whatever its live value is.
- R6: With all three enables low, the flag never sets.
- R7: The hour match compares the alarm hour with `live_hour[4:0]` only. `live_hour[7:5]` (day of week) has no effect.
- R8: Once set, the flag holds until an edge with `alarm_clr` high and no match. If a match coincides with `alarm_clr`, the flag stays set.
- R9: A written alarm value takes part in the comparison from the edge after the write. A match evaluated on the write edge uses the previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Backup-power-loss reset, active low, synchronous |
| rst_n | input | 1 | Ordinary reset, active low, synchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| live_sec | input | 6 | Running seconds value |
| live_min | input | 6 | Running minutes value |
| live_hour | input | 8 | Running hour in [4:0], day of week in [7:5] |
| en_sec | input | 1 | Second compare enable |
| en_min | input | 1 | Minute compare enable |
| en_hr | input | 1 | Hour compare enable |
| alarm_clr | input | 1 | Flag clear strobe |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
Read data follows `bus_addr` within the same cycle. A written value therefore shows up on `bus_rdata` just after the write edge. The alarm flag is due one edge after the live values, enables and clear strobe it is computed from, and a new alarm value enters the match one edge after its write. The bench drives all inputs just after the falling edge and advances its reference model on the rising edge from those held inputs. It compares flag and read data at the next falling edge, so every result is checked in the first half-cycle in which it is due.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int unsigned NUM_FIELDS = 3;
   typedef enum logic [1:0] {FLD_SEC = 2'd0, FLD_MIN = 2'd1, FLD_HR = 2'd2} field_e;

   function automatic logic [7:0] field_mask(input int unsigned width);
      return 8'((9'd1 << width) - 9'd1);
   endfunction
endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg #(
   parameter int unsigned W       = 6,
   parameter int unsigned AW      = 8,
   parameter int unsigned DW      = 8,
   parameter logic [AW-1:0] ADDR  = '0,
   parameter logic [W-1:0]  POR_VAL = '0
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          sel,
   output logic [W-1:0]  q
);
   assign sel = (addr == ADDR);

   always_ff @(posedge clk) begin
      if (!por_n)
         q <= POR_VAL;
      else if (wr && sel)
         q <= W'(wdata);
   end
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
   parameter int unsigned W  = 6,
   parameter int unsigned DW = 8
) (
   input  logic [W-1:0]  alarm,
   input  logic [DW-1:0] live,
   input  logic          en,
   output logic          hit
);
   localparam logic [DW-1:0] LIVE_MASK = DW'((2 ** W) - 1);

   assign hit = !en || ((live & LIVE_MASK) == DW'(alarm));
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!por_n || !rst_n)
         flag <= 1'b0;
      else if (set_evt)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SEC_W     = 6,
   parameter int unsigned MIN_W     = 6,
   parameter int unsigned HR_W      = 5,
   parameter int unsigned LIVE_HR_W = 8,
   parameter logic [ADDR_W-1:0] ADDR_SEC = 8'hF3,
   parameter logic [ADDR_W-1:0] ADDR_MIN = 8'hF4,
   parameter logic [ADDR_W-1:0] ADDR_HR  = 8'hF5,
   parameter logic [SEC_W-1:0]  POR_SEC  = 6'h2A,
   parameter logic [MIN_W-1:0]  POR_MIN  = 6'h15,
   parameter logic [HR_W-1:0]   POR_HR   = 5'h13
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [SEC_W-1:0]     live_sec,
   input  logic [MIN_W-1:0]     live_min,
   input  logic [LIVE_HR_W-1:0] live_hour,
   input  logic                 en_sec,
   input  logic                 en_min,
   input  logic                 en_hr,
   input  logic                 alarm_clr,
   output logic                 alarm_flag
);
   import rtc_alarm_pkg::*;

   localparam int unsigned NF = NUM_FIELDS;

   initial begin
      if (SEC_W > DATA_W || MIN_W > DATA_W || HR_W > DATA_W)
         $error("alarm field wider than data bus");
      if (LIVE_HR_W > DATA_W || LIVE_HR_W < HR_W)
         $error("live hour width out of range");
      if (ADDR_SEC == ADDR_MIN || ADDR_SEC == ADDR_HR || ADDR_MIN == ADDR_HR)
         $error("alarm field addresses overlap");
   end

   logic [DATA_W-1:0]    live_arr [NF];
   logic [DATA_W-1:0]    q_arr    [NF];
   logic [NF-1:0]        sel_vec;
   logic [NF-1:0]        hit_vec;
   logic [NF-1:0]        en_vec;
   logic [NF*DATA_W-1:0] alarm_bits;
   logic                 set_evt;

   assign live_arr[FLD_SEC] = DATA_W'(live_sec);
   assign live_arr[FLD_MIN] = DATA_W'(live_min);
   assign live_arr[FLD_HR]  = DATA_W'(live_hour);
   assign en_vec = {en_hr, en_min, en_sec};

   for (genvar i = 0; i < NF; i++) begin : g_field
      localparam int unsigned FW = (i == 0) ? SEC_W : (i == 1) ? MIN_W : HR_W;
      localparam logic [ADDR_W-1:0] FA =
         (i == 0) ? ADDR_SEC : (i == 1) ? ADDR_MIN : ADDR_HR;
      localparam logic [DATA_W-1:0] PV =
         (i == 0) ? DATA_W'(POR_SEC) : (i == 1) ? DATA_W'(POR_MIN) : DATA_W'(POR_HR);

      logic [FW-1:0] q;

      alarm_field_reg #(
         .W(FW), .AW(ADDR_W), .DW(DATA_W), .ADDR(FA), .POR_VAL(PV[FW-1:0])
      ) u_reg (
         .clk(clk), .por_n(por_n), .wr(bus_wr), .addr(bus_addr),
         .wdata(bus_wdata), .sel(sel_vec[i]), .q(q)
      );

      alarm_field_cmp #(.W(FW), .DW(DATA_W)) u_cmp (
         .alarm(q), .live(live_arr[i]), .en(en_vec[i]), .hit(hit_vec[i])
      );

      assign q_arr[i] = DATA_W'(q);
      assign alarm_bits[i*DATA_W +: DATA_W] = q_arr[i];
   end

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NF; k++)
         if (sel_vec[k]) bus_rdata = q_arr[k];
   end

   assign set_evt = (|en_vec) && (&hit_vec);

   alarm_flag_ctl u_flag (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .set_evt(set_evt), .clr(alarm_clr), .flag(alarm_flag)
   );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned MAX_W  = 6
) (
   input logic                clk,
   input logic                por_n,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                en_sec,
   input logic                en_min,
   input logic                en_hr,
   input logic                alarm_clr,
   input logic                alarm_flag,
   input logic [3*DATA_W-1:0] alarm_bits
);
   assert_por_clears_R1: assert property (@(posedge clk)
      !por_n |=> !alarm_flag);

   assert_rst_clears_R2: assert property (@(posedge clk)
      !rst_n |=> !alarm_flag);

   assert_fields_kept_R2: assert property (@(posedge clk) disable iff (!por_n)
      !bus_wr |=> $stable(alarm_bits));

   assert_rsvd_zero_R3: assert property (@(posedge clk)
      bus_rdata[DATA_W-1:MAX_W] == '0);

   assert_no_enable_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      !alarm_flag && !(en_sec || en_min || en_hr) |=> !alarm_flag);

   assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      alarm_flag && !alarm_clr |=> alarm_flag);

   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      alarm_flag && alarm_clr && !(en_sec || en_min || en_hr) |=> !alarm_flag);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_W(6)
) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
   .bus_rdata(bus_rdata), .en_sec(en_sec), .en_min(en_min), .en_hr(en_hr),
   .alarm_clr(alarm_clr), .alarm_flag(alarm_flag), .alarm_bits(alarm_bits)
);

// File: tb/tb_rtc_alarm_match.sv
`timescale 1ns/1ps
module tb_rtc_alarm_match;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [5:0] live_sec = '0, live_min = '0;
   logic [7:0] live_hour = '0;
   logic       en_sec = 0, en_min = 0, en_hr = 0, alarm_clr = 0;
   logic       alarm_flag;

   always #2 clk = ~clk;

   rtc_alarm_match dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .live_sec(live_sec), .live_min(live_min), .live_hour(live_hour),
      .en_sec(en_sec), .en_min(en_min), .en_hr(en_hr),
      .alarm_clr(alarm_clr), .alarm_flag(alarm_flag)
   );

   int    checks = 0, errors = 0;
   string cur_req = "R1";
   int    m_al[3];
   bit    m_flag = 0;

   function automatic int exp_rdata(input logic [7:0] a);
      case (a)
         8'hF3: return m_al[0];
         8'hF4: return m_al[1];
         8'hF5: return m_al[2];
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit match;
      match = (en_sec || en_min || en_hr)
         && (!en_sec || int'(live_sec) == m_al[0])
         && (!en_min || int'(live_min) == m_al[1])
         && (!en_hr  || int'(live_hour % 32) == m_al[2]);
      if (!por_n) begin
         m_al[0] = 'h2A; m_al[1] = 'h15; m_al[2] = 'h13; m_flag = 0;
      end else begin
         if (!rst_n) m_flag = 0;
         else if (match) m_flag = 1;
         else if (alarm_clr) m_flag = 0;
         if (bus_wr) begin
            if (bus_addr == 8'hF3) m_al[0] = int'(bus_wdata) % 64;
            if (bus_addr == 8'hF4) m_al[1] = int'(bus_wdata) % 64;
            if (bus_addr == 8'hF5) m_al[2] = int'(bus_wdata) % 32;
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(cur_req, "flag", int'(alarm_flag), int'(m_flag));
      chk(cur_req, "rdata", int'(bus_rdata), exp_rdata(bus_addr));
   endtask

   task automatic rd_chk(input logic [7:0] a, input int exp, input string req);
      bus_addr = a;
      #1;
      chk(req, "read", int'(bus_rdata), exp);
      chk(req, "model", exp, exp_rdata(a));
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 0;
   endtask

   task automatic set_live(input int s, input int m, input int h);
      live_sec = 6'(s); live_min = 6'(m); live_hour = 8'(h);
   endtask

   initial begin
      #(4 * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: power-loss reset pattern and cleared flag
      cur_req = "R1";
      tick(); tick();
      por_n = 1; rst_n = 1;
      tick();
      rd_chk(8'hF3, 'h2A, "R1");
      rd_chk(8'hF4, 'h15, "R1");
      rd_chk(8'hF5, 'h13, "R1");
      chk("R1", "flag", int'(alarm_flag), 0);

      // R3: field widths, reserved bits, unmapped address
      cur_req = "R3";
      wr(8'hF3, 8'hFF); rd_chk(8'hF3, 'h3F, "R3");
      wr(8'hF4, 8'hC7); rd_chk(8'hF4, 'h07, "R3");
      wr(8'hF5, 8'hFF); rd_chk(8'hF5, 'h1F, "R3");
      wr(8'hF6, 8'h55); rd_chk(8'hF6, 0, "R3");
      rd_chk(8'hF3, 'h3F, "R3"); rd_chk(8'hF4, 'h07, "R3"); rd_chk(8'hF5, 'h1F, "R3");

      // R4 / R7: full match, day-of-week bits set in live hour
      cur_req = "R4";
      wr(8'hF3, 8'd10); wr(8'hF4, 8'd20); wr(8'hF5, 8'd5);
      set_live(10, 20, 'hE5);
      tick();
      chk("R4", "flag no enable yet", int'(alarm_flag), 0);
      en_sec = 1; en_min = 1; en_hr = 1;
      cur_req = "R7";
      tick();
      chk("R7", "flag with dow bits", int'(alarm_flag), 1);

      // R8: clear without match, clear with coincident match
      cur_req = "R8";
      set_live(11, 20, 5); alarm_clr = 1;
      tick();
      chk("R8", "cleared", int'(alarm_flag), 0);
      set_live(10, 20, 5); tick(); tick();
      chk("R8", "set wins over clear", int'(alarm_flag), 1);
      alarm_clr = 0; set_live(0, 0, 0);
      tick(); tick();
      chk("R8", "sticky", int'(alarm_flag), 1);
      alarm_clr = 1; tick(); alarm_clr = 0;

      // R5: only seconds enabled, minute and hour mismatch
      cur_req = "R5";
      en_min = 0; en_hr = 0; set_live(10, 33, 17);
      tick();
      chk("R5", "disabled fields ignored", int'(alarm_flag), 1);
      alarm_clr = 1; set_live(9, 33, 17); tick(); alarm_clr = 0;
      en_sec = 0; en_hr = 1; set_live(9, 33, 'h25);
      tick();
      chk("R5", "hour only", int'(alarm_flag), 1);
      alarm_clr = 1; set_live(9, 33, 6); tick(); alarm_clr = 0;

      // R6: no enables, all fields equal
      cur_req = "R6";
      en_hr = 0; set_live(10, 20, 5);
      for (int k = 0; k < 4; k++) tick();
      chk("R6", "never sets", int'(alarm_flag), 0);

      // R9: match on the write edge uses the previous value
      cur_req = "R9";
      en_sec = 1; set_live(10, 0, 0);
      bus_wr = 1; bus_addr = 8'hF3; bus_wdata = 8'd33;
      tick();
      bus_wr = 0;
      chk("R9", "old value matched", int'(alarm_flag), 1);
      alarm_clr = 1; tick(); alarm_clr = 0;
      chk("R9", "new value no match", int'(alarm_flag), 0);
      set_live(33, 0, 0); tick();
      chk("R9", "new value match", int'(alarm_flag), 1);

      // R2: ordinary reset clears flag and keeps fields
      cur_req = "R2";
      rst_n = 0; tick(); tick(); rst_n = 1; en_sec = 0;
      tick();
      chk("R2", "flag cleared", int'(alarm_flag), 0);
      rd_chk(8'hF3, 33, "R2"); rd_chk(8'hF4, 20, "R2"); rd_chk(8'hF5, 5, "R2");

      // R1 again: power-loss reset reloads pattern
      cur_req = "R1";
      por_n = 0; tick(); por_n = 1; tick();
      rd_chk(8'hF3, 'h2A, "R1"); rd_chk(8'hF5, 'h13, "R1");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule